// File: doc/BRIEF.md
# Self-Synchronous Link Scrambler

This block whitens the octet stream of a serial converter link before line coding. It sits after tail-bit insertion and ahead of the 8b/10b encoder. Each clock it takes one beat of `OCTETS` octets and runs the multiplicative recurrence 1 + x^14 + x^15 over all of the beat's bits. The recurrence is unrolled so that every bit of the beat is handled in one cycle, and the 15-bit history carries over from one beat to the next. The history is always the last fifteen bits put on the line. Because of that, a receiver needs no seed exchange: after fifteen good bits it is in step with the transmitter.

A matching descrambler is part of the block so that the link can be checked in loopback. The transmit path and the receive path each have their own mode state machine with two states, `MODE_PASS` and `MODE_MIX`. The state register loads the enable input on every clock. Transition `PASS->MIX` happens when the enable is high and transition `MIX->PASS` happens when it is low, so a change of enable affects the beats of the next cycle onward. In `MODE_PASS` the data goes through unchanged, but the history keeps shifting in line bits. A later move into `MODE_MIX` therefore starts from a well-defined history.

Bit order on the line is most significant bit first. The octet in the upper bits of a beat goes out first.

Top module: `ssl_link_scrambler`

## Requirements
- R1: While reset is asserted and at its release, `line_valid` and `rx_valid` are 0, `line_data` and `rx_data` are all zeros, and both paths are in `MODE_PASS`.
- R2: `line_valid` equals `tx_valid` one cycle earlier, and `rx_valid` equals `rx_line_valid` one cycle earlier.
- R3: In `MODE_MIX` each line bit is the data bit XOR the line bits sent 14 and 15 bit times earlier. Bit index DW-1 is sent first and bit 0 last. The first history is the parameter `SEED`.
- R4: In `MODE_PASS` the `line_data` of a beat equals the `tx_data` of that beat, with one cycle of latency.
- R5: In `MODE_PASS` the transmit history still shifts in the line bits, so the first beat scrambled after a switch uses the last 15 bits that went out.
- R6: A mode state register loads its enable input on every clock (`scr_en` for transmit, `rx_scr_en` for receive). A beat accepted in cycle t uses the enable value sampled in cycle t-1.
- R7: When `rx_line_data` is `line_data` unchanged and `rx_scr_en` is `scr_en` delayed one cycle, `rx_data` reproduces `tx_data` two cycles later in both modes.
- R8: In `MODE_MIX` each descrambled bit is the received bit XOR the received bits 14 and 15 bit times earlier. A corrupted line beat therefore disturbs at most that beat and the next beat of 16 bits. Output is exact again from the beat after that, with no reseeding.
- R9: In a cycle without a valid input on a path, that path's output data holds, its valid output is 0 in the next cycle, and its history does not move.
- R10: In `MODE_PASS` the descrambler passes `rx_line_data` to `rx_data` unchanged, while its history shifts in the received bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scr_en | input | 1 | Transmit scramble enable; registered into the transmit mode state |
| tx_valid | input | 1 | Transmit beat strobe |
| tx_data | input | 8*OCTETS | Transmit beat, first octet in the upper bits |
| line_valid | output | 1 | Scrambled beat strobe |
| line_data | output | 8*OCTETS | Scrambled beat toward the line coder |
| rx_scr_en | input | 1 | Receive descramble enable; registered into the receive mode state |
| rx_line_valid | input | 1 | Received beat strobe |
| rx_line_data | input | 8*OCTETS | Received scrambled beat |
| rx_valid | output | 1 | Descrambled beat strobe |
| rx_data | output | 8*OCTETS | Descrambled beat |

## Verification
The relation checks assume that the inputs of a path carry known values whenever that path's strobe is high. They also assume the beat is wide enough that both taps of some bits lie inside the same beat. The stimulus drives every input at the falling edge with defined values. It keeps `rx_scr_en` exactly one cycle behind `scr_en`, so loopback agreement is expected apart from deliberately corrupted beats. Each error is injected only on a line beat that is then followed by clean beats, so the bench can tell where the disturbance should end.

// File: rtl/ssl_pkg.sv
`timescale 1ns/1ps
package ssl_pkg;

    // Length of the scrambler history and the two feedback taps (bit times back)
    localparam int HIST_W = 15;
    localparam int TAP_NEAR = 14;
    localparam int TAP_FAR = 15;

    typedef enum logic {
        MODE_PASS = 1'b0,
        MODE_MIX  = 1'b1
    } mode_e;

endpackage

// File: rtl/ssl_mode_fsm.sv
`timescale 1ns/1ps
module ssl_mode_fsm
    import ssl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    output mode_e mode
);

    mode_e state_q;
    mode_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_PASS;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_PASS: if (enable)  state_d = MODE_MIX;
            MODE_MIX:  if (!enable) state_d = MODE_PASS;
            default:   state_d = MODE_PASS;
        endcase
    end

    assign mode = state_q;

endmodule

// File: rtl/ssl_mixer.sv
`timescale 1ns/1ps
module ssl_mixer
    import ssl_pkg::*;
#(
    parameter int DW = 16,
    parameter logic [HIST_W-1:0] SEED = '1,
    parameter bit DESCRAMBLE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;
    logic [DW-1:0]     mix_bits;
    logic [DW-1:0]     line_bits;

    // The history always holds line-side bits: the output bits when
    // scrambling, the input bits when descrambling.
    generate
        if (DESCRAMBLE) begin : g_rx_side
            assign line_bits = in_data;
        end else begin : g_tx_side
            assign line_bits = mix_bits;
        end
    endgenerate

    // Unrolled recurrence, most significant bit first
    always_comb begin
        logic [HIST_W-1:0] h;
        logic fb;
        h = hist_q;
        mix_bits = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = h[TAP_NEAR-1] ^ h[TAP_FAR-1];
            mix_bits[i] = in_data[i] ^ ((mode == MODE_MIX) & fb);
            h = {h[HIST_W-2:0], (DESCRAMBLE ? in_data[i] : mix_bits[i])};
        end
        hist_d = h;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q    <= SEED;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hist_q   <= hist_d;
                out_data <= mix_bits;
            end
        end
    end

    logic unused_line;
    assign unused_line = ^line_bits;

endmodule

// File: rtl/ssl_link_scrambler.sv
`timescale 1ns/1ps
module ssl_link_scrambler
    import ssl_pkg::*;
#(
    parameter int OCTETS = 2,
    parameter logic [HIST_W-1:0] SEED = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scr_en,
    input  logic                tx_valid,
    input  logic [8*OCTETS-1:0] tx_data,
    output logic                line_valid,
    output logic [8*OCTETS-1:0] line_data,
    input  logic                rx_scr_en,
    input  logic                rx_line_valid,
    input  logic [8*OCTETS-1:0] rx_line_data,
    output logic                rx_valid,
    output logic [8*OCTETS-1:0] rx_data
);

    localparam int DW = 8 * OCTETS;

    mode_e tx_mode;
    mode_e rx_mode;

    ssl_mode_fsm u_tx_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (scr_en),
        .mode   (tx_mode)
    );

    ssl_mode_fsm u_rx_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (rx_scr_en),
        .mode   (rx_mode)
    );

    ssl_mixer #(.DW(DW), .SEED(SEED), .DESCRAMBLE(1'b0)) u_scr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (tx_mode),
        .in_valid  (tx_valid),
        .in_data   (tx_data),
        .out_valid (line_valid),
        .out_data  (line_data)
    );

    ssl_mixer #(.DW(DW), .SEED(SEED), .DESCRAMBLE(1'b1)) u_dscr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (rx_mode),
        .in_valid  (rx_line_valid),
        .in_data   (rx_line_data),
        .out_valid (rx_valid),
        .out_data  (rx_data)
    );

endmodule

// File: rtl/ssl_link_scrambler_chk.sv
`timescale 1ns/1ps
module ssl_link_scrambler_chk
    import ssl_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scr_en,
    input logic          tx_valid,
    input logic [DW-1:0] tx_data,
    input logic          line_valid,
    input logic [DW-1:0] line_data,
    input logic          rx_line_valid,
    input logic [DW-1:0] rx_line_data,
    input logic          rx_valid,
    input logic [DW-1:0] rx_data,
    input mode_e         tx_mode,
    input mode_e         rx_mode
);

    // High once a full clocked cycle has passed outside reset
    logic seen;
    always_ff @(posedge clk) begin
        seen <= rst_n;
    end

    // R2
    tx_valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> line_valid == $past(tx_valid));

    // R2
    rx_valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> rx_valid == $past(rx_line_valid));

    // R6
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (tx_mode == MODE_MIX) == $past(scr_en));

    // R4
    tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(tx_valid) && ($past(tx_mode) == MODE_PASS) |-> line_data == $past(tx_data));

    // R10
    rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rx_line_valid) && ($past(rx_mode) == MODE_PASS) |-> rx_data == $past(rx_line_data));

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(tx_valid) |-> $stable(line_data));

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(rx_line_valid) |-> $stable(rx_data));

    generate
        for (genvar j = 0; j + TAP_FAR < DW; j++) begin : g_taps
            // R3
            tx_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                seen && $past(tx_valid) && ($past(tx_mode) == MODE_MIX) |->
                (line_data[j] ^ line_data[j+TAP_NEAR] ^ line_data[j+TAP_FAR]) == $past(tx_data[j]));
            // R8
            rx_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                seen && $past(rx_line_valid) && ($past(rx_mode) == MODE_MIX) |->
                rx_data[j] == $past(rx_line_data[j] ^ rx_line_data[j+TAP_NEAR] ^ rx_line_data[j+TAP_FAR]));
        end
    endgenerate

endmodule

bind ssl_link_scrambler ssl_link_scrambler_chk #(.DW(8 * OCTETS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scr_en        (scr_en),
    .tx_valid      (tx_valid),
    .tx_data       (tx_data),
    .line_valid    (line_valid),
    .line_data     (line_data),
    .rx_line_valid (rx_line_valid),
    .rx_line_data  (rx_line_data),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .tx_mode       (tx_mode),
    .rx_mode       (rx_mode)
);

// File: tb/test_ssl_link_scrambler.sv
`timescale 1ns/1ps
module test_ssl_link_scrambler;

    localparam int OCTETS = 2;
    localparam int DW = 8 * OCTETS;
    localparam logic [14:0] SEED = 15'h7FFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scr_en = 1'b0;
    logic          tx_valid = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          line_valid;
    logic [DW-1:0] line_data;
    logic          rx_scr_en = 1'b0;
    logic          rx_line_valid;
    logic [DW-1:0] rx_line_data;
    logic          rx_valid;
    logic [DW-1:0] rx_data;
    logic [DW-1:0] err_mask = '0;

    assign rx_line_valid = line_valid;
    assign rx_line_data  = line_data ^ err_mask;

    always #2 clk = ~clk;

    ssl_link_scrambler #(.OCTETS(OCTETS), .SEED(SEED)) i_ssl_link_scrambler (
        .clk           (clk),
        .rst_n         (rst_n),
        .scr_en        (scr_en),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .line_valid    (line_valid),
        .line_data     (line_data),
        .rx_scr_en     (rx_scr_en),
        .rx_line_valid (rx_line_valid),
        .rx_line_data  (rx_line_data),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    logic [14:0]   h_tx = SEED, h_rx = SEED;
    bit            m_tx = 0, m_rx = 0, en_prev = 0;
    bit            pv1 = 0, pv2 = 0;
    logic [DW-1:0] e_line1 = '0, d1 = '0, e_rx2 = '0, d2 = '0;
    logic [DW-1:0] last_line = '0, last_rx = '0;
    int            since_err = 2, age2 = 2;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Returns {new history, output beat}; bits go MSB first
    function automatic logic [15+DW-1:0] model(input logic [14:0] h, input logic [DW-1:0] x,
                                                input bit on, input bit desc);
        logic [14:0]   s;
        logic [DW-1:0] y;
        s = h;
        y = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            y[i] = x[i] ^ (on & (s[13] ^ s[14]));
            s = {s[13:0], (desc ? x[i] : y[i])};
        end
        return {s, y};
    endfunction

    task automatic cyc(input bit v, input logic [DW-1:0] d, input bit en, input logic [DW-1:0] err);
        logic [15+DW-1:0] r;
        @(negedge clk);
        // outputs produced at the last edge
        if (pv1) begin
            chk(line_valid === 1'b1 && line_data === e_line1,
                m_tx ? "R3 R5 R6 scrambled line beat" : "R4 pass line beat", line_data, e_line1);
        end else begin
            chk(line_valid === 1'b0 && line_data === last_line, "R2 R9 line idle hold", line_data, last_line);
        end
        if (pv2) begin
            chk(rx_valid === 1'b1 && rx_data === e_rx2, "R8 R10 rx beat", rx_data, e_rx2);
            if (age2 >= 2)
                chk(rx_data === d2, "R7 loopback", rx_data, d2);
        end else begin
            chk(rx_valid === 1'b0 && rx_data === last_rx, "R2 R9 rx idle hold", rx_data, last_rx);
        end
        last_line = line_data;
        last_rx   = rx_data;
        // receive beat taken at the coming edge
        pv2 = pv1;
        if (pv1) begin
            r = model(h_rx, e_line1 ^ err, m_rx, 1'b1);
            h_rx  = r[15+DW-1:DW];
            e_rx2 = r[DW-1:0];
            d2    = d1;
            if (err != '0) since_err = 0;
            else if (since_err < 2) since_err++;
            age2 = since_err;
            err_mask = err;
        end else begin
            err_mask = '0;
        end
        m_rx = en_prev;
        rx_scr_en = en_prev;
        // transmit beat taken at the coming edge
        tx_valid = v;
        tx_data  = d;
        pv1 = v;
        if (v) begin
            r = model(h_tx, d, m_tx, 1'b0);
            h_tx    = r[15+DW-1:DW];
            e_line1 = r[DW-1:0];
            d1      = d;
        end
        m_tx = en;
        scr_en = en;
        en_prev = en;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(line_valid === 1'b0 && line_data === '0, "R1 line reset", line_data, '0);
        chk(rx_valid === 1'b0 && rx_data === '0, "R1 rx reset", rx_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_valid === 1'b0 && rx_valid === 1'b0, "R1 after release", {15'd0, line_valid}, '0);
        // R1 R4: bypass right out of reset
        for (int i = 0; i < 40; i++) cyc(1'b1, DW'(i * 16'h1357 + 16'h00F1), 1'b0, '0);
        // R3: full sweep of beat values with scrambling, idle gaps for R9
        for (int i = 0; i < 65536; i++) begin
            cyc(1'b1, DW'(i), 1'b1, '0);
            if ((i % 509) == 0) cyc(1'b0, 16'hDEAD, 1'b1, '0);
        end
        // R3: constant patterns
        for (int i = 0; i < 64; i++) cyc(1'b1, 16'h0000, 1'b1, '0);
        for (int i = 0; i < 64; i++) cyc(1'b1, 16'hFFFF, 1'b1, '0);
        // R4 R5 R10: bypass with history still moving
        for (int i = 0; i < 300; i++) cyc(1'b1, DW'(i * 16'h9E37), 1'b0, '0);
        // R5 R6: switch while streaming, enable toggling at several spacings
        for (int i = 0; i < 600; i++) cyc(1'b1, DW'(i * 16'h3C5B ^ 16'h5A5A), ((i % 7) < 3) || ((i % 11) == 0), '0);
        // R8: single and burst line errors in scramble mode
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < 5; i++) cyc(1'b1, DW'(k * 16'h0BAD + i), 1'b1, '0);
            cyc(1'b1, DW'(k * 16'h7777), 1'b1, DW'(16'h0001 << (k % 16)) | DW'((k % 3 == 0) ? 16'h8000 : 16'h0000));
        end
        // R8 R10: error in pass mode affects only that beat
        for (int i = 0; i < 5; i++) cyc(1'b1, DW'(i), 1'b0, '0);
        cyc(1'b1, 16'h1234, 1'b0, 16'h00FF);
        for (int i = 0; i < 8; i++) cyc(1'b1, DW'(i * 3), 1'b0, '0);
        for (int i = 0; i < 4; i++) cyc(1'b0, '0, 1'b0, '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule